// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM out of power-up and into a known state before a normal-operation controller takes over. After reset it holds the command bus inhibited. When a start pulse arrives it drives NOP for a long stabilisation window, precharges every bank, issues a programmable number of auto-refresh commands, and then loads the mode register. After that it signals that it is finished and keeps driving NOP.

Every gap between commands is given in clock cycles as an elaboration parameter. The stabilisation window is derived from the memory clock frequency in MHz and the wait in microseconds. The mode-register op-code is built from the burst length code, the burst type, the write-burst mode and a CAS latency. The CAS latency is chosen from the clock frequency. Clock enable stays high throughout. The command is encoded on {cs_n, ras_n, cas_n, we_n}, and all outputs come straight from registers.

Top module: `sdram_powerup_seq`

## Requirements
- R1: After a synchronous reset, and until a start pulse is accepted, the command is INHIBIT ({cs_n,ras_n,cas_n,we_n} = 1111), init_done is 0, and the address and bank outputs are 0.
- R2: The cycle after start is sampled high in the idle state, the block drives NOP (0111) for exactly CLK_MHZ*WAIT_US consecutive cycles. PRECHARGE follows in the next cycle.
- R3: The precharge-all command is encoded 0010, with address bit 10 high, every other address bit 0, and the bank outputs 0.
- R4: The first AUTO REFRESH follows the precharge cycle by exactly T_RP cycles.
- R5: Exactly N_REFRESH AUTO REFRESH commands (0001) are issued, each following the previous one by T_RFC cycles. The mode load follows the last refresh by T_RFC cycles. The command order is precharge, then the refreshes, then the mode load.
- R6: The LOAD MODE command is encoded 0000 with the bank outputs 0. Its address carries burst length code in bits 2:0, burst type (1 = interleaved) in bit 3, CAS latency in bits 6:4, 00 in bits 8:7, write-burst single-location flag in bit 9, and 0 above bit 9.
- R7: The CAS latency field is 2 when CLK_MHZ is 100 or more, and 3 otherwise.
- R8: Every cycle of the sequence that is not a command cycle, and every cycle after it completes, carries NOP with the address and bank outputs 0.
- R9: init_done rises exactly T_MRD cycles after the LOAD MODE cycle, and stays high until reset.
- R10: Start pulses after the first accepted one have no effect until reset, whether they arrive during the sequence or after it completes.
- R11: sd_cke is 1 in every cycle.
- R12: A reset in the middle of the sequence returns the block to the R1 state. A later start runs the whole sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the power-up sequence when high in the idle state |
| init_done | output | 1 | High once the sequence has completed |
| sd_cke | output | 1 | SDRAM clock enable, always high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus, carries bit 10 for precharge-all and the mode op-code |

## Verification
The bench builds two instances side by side.

The first instance runs at a nominal 50 MHz with a 2 µs window, which gives a 100-cycle wait and selects CAS latency 3. It uses burst length 4, sequential bursts, T_RP=3, T_RFC=7 and T_MRD=2.

The second instance runs at a nominal 133 MHz with a 1 µs window, which gives a 133-cycle wait and selects CAS latency 2. It uses burst length 8, interleaved bursts, single-location writes, T_RP=2, T_RFC=5 and T_MRD=3.

The shortened windows make complete sequences, repeated starts and a reset part-way through the wait affordable. The two configurations exercise both sides of the CAS-latency threshold, and every field of the op-code takes a non-default value in at least one of them.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE_GAP,
    ST_REF_GAP,
    ST_MRD_GAP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/sdr_gap_timer.sv
// Down-counter shared by all waits of the sequence; load has priority.
module sdr_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdr_mode_word.sv
// Builds the mode-register op-code carried on the address bus.
module sdr_mode_word #(
  parameter int         ADDR_W       = 13,
  parameter int         CAS_LAT      = 2,
  parameter logic [2:0] BL_CODE      = 3'b010,
  parameter logic       INTERLEAVE   = 1'b0,
  parameter logic       WRITE_SINGLE = 1'b0
) (
  output logic [ADDR_W-1:0] op
);
  localparam int FIELD_W = 10;

  always_comb begin
    op        = '0;
    op[2:0]   = BL_CODE;
    op[3]     = INTERLEAVE;
    op[6:4]   = 3'(CAS_LAT);
    op[8:7]   = 2'b00;
    op[FIELD_W-1] = WRITE_SINGLE;
  end
endmodule

// File: rtl/sdr_cmd_reg.sv
// Output register stage: every pin toward the memory leaves a flop.
module sdr_cmd_reg #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic              done_d,
  output logic [3:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BA_W-1:0]   ba_q,
  output logic              done_q,
  output logic              cke_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 4'b1111;
      addr_q <= '0;
      ba_q   <= '0;
      done_q <= 1'b0;
      cke_q  <= 1'b1;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      ba_q   <= ba_d;
      done_q <= done_d;
      cke_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int         CLK_MHZ      = 100,
  parameter int         WAIT_US      = 100,
  parameter int         T_RP         = 2,
  parameter int         T_RFC        = 6,
  parameter int         T_MRD        = 2,
  parameter int         N_REFRESH    = 8,
  parameter int         ADDR_W       = 13,
  parameter int         BA_W         = 2,
  parameter logic [2:0] BL_CODE      = 3'b010,
  parameter logic       INTERLEAVE   = 1'b0,
  parameter logic       WRITE_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CAS_LAT  = (CLK_MHZ >= 100) ? 2 : 3;
  localparam int AP_BIT   = 10;
  localparam int GAP_A    = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GAP_B    = (GAP_A > T_MRD) ? GAP_A : T_MRD;
  localparam int MAX_GAP  = (WAIT_CYC > GAP_B) ? WAIT_CYC : GAP_B;
  localparam int CNT_W    = $clog2(MAX_GAP + 1);
  localparam int RC_W     = $clog2(N_REFRESH + 1);

  seq_state_e        st_q, st_nxt;
  sdr_cmd_e          cmd_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] mode_op;
  logic [RC_W-1:0]   rcnt_q, rcnt_nxt;
  logic              tmr_load, tmr_zero, done_nxt;
  logic [CNT_W-1:0]  tmr_val;
  logic [3:0]        cmd_q;

  sdr_mode_word #(
    .ADDR_W(ADDR_W), .CAS_LAT(CAS_LAT), .BL_CODE(BL_CODE),
    .INTERLEAVE(INTERLEAVE), .WRITE_SINGLE(WRITE_SINGLE)
  ) u_mode (.op(mode_op));

  sdr_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // Next command is decided one cycle ahead; the output stage registers it.
  always_comb begin
    st_nxt   = st_q;
    cmd_nxt  = CMD_NOP;
    addr_nxt = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rcnt_nxt = rcnt_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_nxt   = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WAIT_CYC - 1);
        end else begin
          cmd_nxt  = CMD_INH;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          cmd_nxt          = CMD_PRE;
          addr_nxt[AP_BIT] = 1'b1;
          tmr_load         = 1'b1;
          tmr_val          = CNT_W'(T_RP - 1);
          st_nxt           = ST_PRE_GAP;
        end
      end
      ST_PRE_GAP: begin
        if (tmr_zero) begin
          cmd_nxt  = CMD_REF;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RFC - 1);
          rcnt_nxt = RC_W'(N_REFRESH - 1);
          st_nxt   = ST_REF_GAP;
        end
      end
      ST_REF_GAP: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (rcnt_q != '0) begin
            cmd_nxt  = CMD_REF;
            tmr_val  = CNT_W'(T_RFC - 1);
            rcnt_nxt = rcnt_q - RC_W'(1);
          end else begin
            cmd_nxt  = CMD_LMR;
            addr_nxt = mode_op;
            tmr_val  = CNT_W'(T_MRD - 1);
            st_nxt   = ST_MRD_GAP;
          end
        end
      end
      ST_MRD_GAP: begin
        if (tmr_zero) st_nxt = ST_DONE;
      end
      ST_DONE: ;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign done_nxt = ((st_q == ST_MRD_GAP) && tmr_zero) || (st_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      rcnt_q <= '0;
    end else begin
      st_q   <= st_nxt;
      rcnt_q <= rcnt_nxt;
    end
  end

  sdr_cmd_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
    .clk(clk), .rst(rst),
    .cmd_d(cmd_nxt), .addr_d(addr_nxt), .ba_d('0), .done_d(done_nxt),
    .cmd_q(cmd_q), .addr_q(sd_addr), .ba_q(sd_ba), .done_q(init_done),
    .cke_q(sd_cke)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
endmodule

// File: rtl/sdram_powerup_chk.sv
module sdram_powerup_chk #(
  parameter int BA_W  = 2,
  parameter int T_RP  = 2,
  parameter int T_RFC = 6,
  parameter int T_MRD = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            init_done,
  input logic            sd_cs_n,
  input logic            sd_ras_n,
  input logic            sd_cas_n,
  input logic            sd_we_n,
  input logic            a10,
  input logic [BA_W-1:0] sd_ba
);
  logic [3:0]  cmd;
  logic        is_cmd, seen_start;
  logic [15:0] gap_q;
  logic [3:0]  last_q;

  assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd = !sd_cs_n && (cmd != 4'b0111);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_start <= 1'b0;
      gap_q      <= '0;
      last_q     <= 4'b1111;
    end else begin
      if (start) seen_start <= 1'b1;
      if (is_cmd) begin
        gap_q  <= 16'd1;
        last_q <= cmd;
      end else if (gap_q != 16'hFFFF) begin
        gap_q  <= gap_q + 16'd1;
      end
    end
  end

  // R1
  idle_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_start |-> sd_cs_n);

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (a10 && sd_ba == '0));

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0001 && last_q == 4'b0010) |-> (gap_q >= 16'(T_RP)));

  // R5
  ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 4'b0001 || cmd == 4'b0000) && last_q == 4'b0001) |-> (gap_q >= 16'(T_RFC)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_q == 4'b0000 && gap_q == 16'(T_MRD)));

  // R8
  done_nop_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111));
endmodule

bind sdram_powerup_seq sdram_powerup_chk #(
  .BA_W(BA_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .init_done(init_done),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .a10(sd_addr[10]), .sd_ba(sd_ba)
);

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  localparam int A_MHZ = 50,  A_US = 2, A_RP = 3, A_RFC = 7, A_MRD = 2;
  localparam int B_MHZ = 133, B_US = 1, B_RP = 2, B_RFC = 5, B_MRD = 3;
  localparam int NREF = 8;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic              done;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic done_a, cke_a, cs_a, ras_a, cas_a, we_a;
  logic done_b, cke_b, cs_b, ras_b, cas_b, we_b;
  logic [BA_W-1:0]   ba_a, ba_b;
  logic [ADDR_W-1:0] addr_a, addr_b;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  bit run_a = 0, run_b = 0;
  exp_t q_a[$], q_b[$];
  logic [3:0]        lc_a[$], lc_b[$];
  int                lp_a[$], lp_b[$];
  logic [ADDR_W-1:0] la_a[$], la_b[$];
  int pos_a = 0, pos_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_powerup_seq #(
    .CLK_MHZ(A_MHZ), .WAIT_US(A_US), .T_RP(A_RP), .T_RFC(A_RFC), .T_MRD(A_MRD),
    .N_REFRESH(NREF), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .BL_CODE(3'b010), .INTERLEAVE(1'b0), .WRITE_SINGLE(1'b0)
  ) i_sdram_powerup_seq (
    .clk(clk), .rst(rst), .start(start), .init_done(done_a), .sd_cke(cke_a),
    .sd_cs_n(cs_a), .sd_ras_n(ras_a), .sd_cas_n(cas_a), .sd_we_n(we_a),
    .sd_ba(ba_a), .sd_addr(addr_a)
  );

  sdram_powerup_seq #(
    .CLK_MHZ(B_MHZ), .WAIT_US(B_US), .T_RP(B_RP), .T_RFC(B_RFC), .T_MRD(B_MRD),
    .N_REFRESH(NREF), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .BL_CODE(3'b011), .INTERLEAVE(1'b1), .WRITE_SINGLE(1'b1)
  ) i_sdram_powerup_seq_fast (
    .clk(clk), .rst(rst), .start(start), .init_done(done_b), .sd_cke(cke_b),
    .sd_cs_n(cs_b), .sd_ras_n(ras_b), .sd_cas_n(cas_b), .sd_we_n(we_b),
    .sd_ba(ba_b), .sd_addr(addr_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Op-code layout from R6, CAS latency choice from R7
  function automatic logic [ADDR_W-1:0] mode_of(int mhz, logic [2:0] bl, logic il, logic ws);
    logic [ADDR_W-1:0] r;
    int cl;
    cl = (mhz >= 100) ? 2 : 3;
    r = '0;
    r[2:0] = bl;
    r[3]   = il;
    r[6:4] = 3'(cl);
    r[9]   = ws;
    return r;
  endfunction

  task automatic build(ref exp_t qq[$], input int wcyc, input int trp, input int trfc,
                       input int tmrd, input logic [ADDR_W-1:0] op);
    qq.delete();
    repeat (wcyc) qq.push_back('{4'b0111, '0, 1'b0});
    qq.push_back('{4'b0010, ADDR_W'(1 << 10), 1'b0});
    repeat (trp - 1) qq.push_back('{4'b0111, '0, 1'b0});
    for (int i = 0; i < NREF; i++) begin
      qq.push_back('{4'b0001, '0, 1'b0});
      repeat (trfc - 1) qq.push_back('{4'b0111, '0, 1'b0});
    end
    qq.push_back('{4'b0000, op, 1'b0});
    repeat (tmrd - 1) qq.push_back('{4'b0111, '0, 1'b0});
  endtask

  function automatic string tag_of(logic [3:0] c, logic d);
    if (c == 4'b0010) return "R3";
    if (c == 4'b0001) return "R5";
    if (c == 4'b0000) return "R6";
    if (d) return "R9";
    return "R8";
  endfunction

  task automatic cmp(ref exp_t qq[$], ref logic [3:0] lc[$], ref int lp[$],
                     ref logic [ADDR_W-1:0] la[$], ref int pos, input bit running,
                     input logic [3:0] c, input logic [ADDR_W-1:0] a, input logic [BA_W-1:0] b,
                     input logic d, input logic ke, input string nm);
    exp_t e;
    string t;
    chk(ke === 1'b1, "R11", {nm, " cke"}, ke, 1);
    if (qq.size() > 0) begin
      e = qq.pop_front();
      t = tag_of(e.cmd, e.done);
    end else if (running) begin
      e = '{4'b0111, '0, 1'b1};
      t = "R9";
    end else begin
      e = '{4'b1111, '0, 1'b0};
      t = "R1";
    end
    chk(c === e.cmd,  t, {nm, " command"}, c, e.cmd);
    chk(a === e.addr, t, {nm, " address"}, a, e.addr);
    chk(b === '0,     t, {nm, " bank"}, b, 0);
    chk(d === e.done, t, {nm, " init_done"}, d, e.done);
    if (running) begin
      if (!c[3] && c != 4'b0111) begin
        lc.push_back(c); lp.push_back(pos); la.push_back(a);
      end
      pos++;
    end
  endtask

  always @(negedge clk) begin
    cmp(q_a, lc_a, lp_a, la_a, pos_a, run_a, {cs_a, ras_a, cas_a, we_a}, addr_a, ba_a,
        done_a, cke_a, "A");
    cmp(q_b, lc_b, lp_b, la_b, pos_b, run_b, {cs_b, ras_b, cas_b, we_b}, addr_b, ba_b,
        done_b, cke_b, "B");
  end

  // Recorded command log: order, spacing and mode address
  task automatic verify(ref logic [3:0] lc[$], ref int lp[$], ref logic [ADDR_W-1:0] la[$],
                        input int wcyc, input int trp, input int trfc,
                        input logic [ADDR_W-1:0] op, input int cl, input string nm);
    chk(lc.size() == NREF + 2, "R5", {nm, " command count"}, lc.size(), NREF + 2);
    if (lc.size() != NREF + 2) return;
    chk(lc[0] == 4'b0010, "R5", {nm, " first is precharge"}, lc[0], 4'b0010);
    chk(lp[0] == wcyc, "R2", {nm, " NOP window length"}, lp[0], wcyc);
    chk(lp[1] - lp[0] == trp, "R4", {nm, " precharge to refresh"}, lp[1] - lp[0], trp);
    for (int i = 1; i <= NREF; i++) begin
      chk(lc[i] == 4'b0001, "R5", {nm, " refresh order"}, lc[i], 4'b0001);
      chk(lp[i+1] - lp[i] == trfc, "R5", {nm, " refresh spacing"}, lp[i+1] - lp[i], trfc);
    end
    chk(lc[NREF+1] == 4'b0000, "R5", {nm, " last is mode load"}, lc[NREF+1], 4'b0000);
    chk(la[NREF+1] == op, "R6", {nm, " mode op-code"}, la[NREF+1], op);
    chk(la[NREF+1][6:4] == 3'(cl), "R7", {nm, " CAS latency field"}, la[NREF+1][6:4], cl);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic arm();
    build(q_a, A_MHZ * A_US, A_RP, A_RFC, A_MRD, mode_of(A_MHZ, 3'b010, 1'b0, 1'b0));
    build(q_b, B_MHZ * B_US, B_RP, B_RFC, B_MRD, mode_of(B_MHZ, 3'b011, 1'b1, 1'b1));
    lc_a.delete(); lp_a.delete(); la_a.delete(); pos_a = 0;
    lc_b.delete(); lp_b.delete(); la_b.delete(); pos_b = 0;
    run_a = 1; run_b = 1;
  endtask

  task automatic pulse_start(input bit accept);
    start = 1'b1; tick(); start = 1'b0;
    if (accept) arm();
  endtask

  task automatic finish_run();
    while (q_a.size() > 0 || q_b.size() > 0) tick();
    repeat (4) tick();
    verify(lc_a, lp_a, la_a, A_MHZ * A_US, A_RP, A_RFC, mode_of(A_MHZ, 3'b010, 1'b0, 1'b0), 3, "A");
    verify(lc_b, lp_b, la_b, B_MHZ * B_US, B_RP, B_RFC, mode_of(B_MHZ, 3'b011, 1'b1, 1'b1), 2, "B");
  endtask

  // R12: reset lands one edge later; the model is cleared once it has
  task automatic do_reset();
    rst = 1'b1; tick();
    q_a.delete(); q_b.delete(); run_a = 0; run_b = 0;
    chk(cs_a === 1'b1 && done_a === 1'b0, "R12", "A state after reset", {cs_a, done_a}, 2'b10);
    chk(cs_b === 1'b1 && done_b === 1'b0, "R12", "B state after reset", {cs_b, done_b}, 2'b10);
    tick(); rst = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    repeat (6) tick();
    pulse_start(1);
    repeat (20) tick();
    pulse_start(0);                  // R10: ignored during the wait
    finish_run();
    pulse_start(0);                  // R10: ignored after completion
    repeat (10) tick();
    chk(done_a === 1'b1 && done_b === 1'b1, "R10", "init_done after late start",
        {done_a, done_b}, 2'b11);
    do_reset();
    repeat (4) tick();
    pulse_start(1);
    repeat (40) tick();
    do_reset();                      // R12: mid-sequence reset
    repeat (5) tick();
    pulse_start(1);
    finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule